// File: doc/BRIEF.md
# Primitive Polynomial Tester

This block decides whether a binary polynomial of degree n is primitive. The caller supplies the degree and the n low coefficients of a monic polynomial P, together with the distinct prime divisors of 2^n-1 and how many of them are valid. It then pulses start. The engine raises x to powers modulo P by left-to-right square-and-multiply. Each modular squaring runs bit-serially, with one shift, one conditional reduction and one conditional accumulate per cycle. A multiply by x needs only one reduction step and folds into the same cycle that accepts the squared product.

The test runs in stages. First, x raised to the full period 2^n-1 must reduce to the constant 1. Then, for each listed prime p, the engine computes the cofactor exponent (2^n-1)/p with a bit-serial restoring divider, and x raised to that exponent must not reduce to 1. The first stage that fails ends the run with a negative answer. When every stage holds, the answer is positive. Finding the prime divisors and searching for candidate polynomials are left to the caller.

Top module: `ppt_tester`

## Requirements
- R1: For a primitive polynomial with its complete list of distinct prime divisors of 2^n-1, the block reports is_primitive = 1. Coefficient encoding: bit i of poly_low is the coefficient of x^i, and the x^n term is implied by poly_deg.
- R2: When x^(2^n-1) mod P is not 1, the block reports 0. An example is a polynomial with an even number of nonzero terms, which P(1)=0 makes divisible by x+1.
- R3: When some listed prime p gives x^((2^n-1)/p) mod P = 1, the block reports 0. Only the first fac_cnt entries of factors are used, with entry k in bits [k*MAX_DEG +: MAX_DEG]. A fac_cnt above MAX_FACT is treated as MAX_FACT.
- R4: With fac_cnt = 0, only the full-period check is applied. This covers the case where 2^n-1 is prime, for example degree 7 with period 127.
- R5: If the constant coefficient is 0, or poly_deg is 0 or above MAX_DEG, done is high in the cycle after start with is_primitive = 0, and busy never rises.
- R6: Bits of poly_low at positions poly_deg and above have no effect on the result.
- R7: For an accepted start that passes the R5 checks, busy is high from the next cycle until done. done is a one-cycle pulse, and busy is low while done is high.
- R8: is_primitive is valid while done is high. It keeps its value until the next accepted start.
- R9: A start while busy is ignored. All inputs, including the factor list, are sampled only at an accepted start.
- R10: After reset, busy, done and is_primitive are all 0.
- R11: Degree 1 works: x+1 is reported primitive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test (accepted when not busy) |
| poly_deg | input | DEG_W | Degree n of P |
| poly_low | input | MAX_DEG | Coefficients of x^0..x^(n-1) |
| fac_cnt | input | CNT_W | Number of valid prime entries |
| factors | input | MAX_FACT*MAX_DEG | Packed list of prime divisors of 2^n-1 |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle completion pulse |
| is_primitive | output | 1 | Verdict, valid with done |

## Verification
The bench targets five corner cases:

- An irreducible but non-primitive quartic (order 5). It passes the full-period check and is caught only by the prime-3 cofactor, so an engine that skipped or mis-divided the cofactor stage would call it primitive.
- Degree 1 and degree 16. At these extremes, an off-by-one in the bit counters or the reduction mask would break the result.
- Rejected inputs. These must finish in one cycle, so a design that runs the engine on them would show busy.
- Garbage above the degree, factor entries beyond the count, and factor inputs changed mid-run. A design that reads these would change its verdict.
- Random polynomials with complete and truncated factor lists. These are compared against a bench model that finds the true multiplicative order by single stepping.

// File: rtl/ppt_pkg.sv
package ppt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PREP  = 3'd1,
        ST_DIVW  = 3'd2,
        ST_EINIT = 3'd3,
        ST_SQGO  = 3'd4,
        ST_SQW   = 3'd5,
        ST_EVAL  = 3'd6
    } ppt_state_e;

endpackage

// File: rtl/ppt_xstep.sv
// One multiply-by-x step modulo P for a residue of degree below deg.
module ppt_xstep #(
    parameter int W     = 16,
    parameter int DEG_W = 5
) (
    input  logic [W-1:0]     v,
    input  logic [W-1:0]     plow,
    input  logic [DEG_W-1:0] deg,
    output logic [W-1:0]     vx
);
    logic [W-1:0] mask;
    logic         msb;

    always_comb begin
        mask = '0;
        msb  = 1'b0;
        for (int i = 0; i < W; i++) begin
            mask[i] = (i < int'(deg));
            if (i == int'(deg) - 1) msb = v[i];
        end
        vx = ({v[W-2:0], 1'b0} & mask) ^ (msb ? (plow & mask) : '0);
    end
endmodule

// File: rtl/ppt_mulmod.sv
// Bit-serial modular multiply: MSB-first Horner, deg cycles per product.
module ppt_mulmod #(
    parameter int W     = 16,
    parameter int DEG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [W-1:0]     plow,
    input  logic [DEG_W-1:0] deg,
    output logic [W-1:0]     prod,
    output logic             rdy
);
    typedef struct packed {
        logic             busy;
        logic             rdy;
        logic [W-1:0]     a;
        logic [W-1:0]     b;
        logic [W-1:0]     acc;
        logic [DEG_W-1:0] idx;
    } mm_t;

    mm_t          mm_q, mm_d;
    logic [W-1:0] acc_x;
    logic         bsel;

    ppt_xstep #(.W(W), .DEG_W(DEG_W)) u_step (
        .v(mm_q.acc), .plow(plow), .deg(deg), .vx(acc_x)
    );

    always_comb begin
        bsel = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (i == int'(mm_q.idx)) bsel = mm_q.b[i];
        end
        mm_d     = mm_q;
        mm_d.rdy = 1'b0;
        if (go) begin
            mm_d.a    = a;
            mm_d.b    = b;
            mm_d.acc  = '0;
            mm_d.idx  = deg - DEG_W'(1);
            mm_d.busy = 1'b1;
        end else if (mm_q.busy) begin
            mm_d.acc = acc_x ^ (bsel ? mm_q.a : '0);
            if (mm_q.idx == '0) begin
                mm_d.busy = 1'b0;
                mm_d.rdy  = 1'b1;
            end else begin
                mm_d.idx = mm_q.idx - DEG_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mm_q <= '0;
        else        mm_q <= mm_d;
    end

    assign prod = mm_q.acc;
    assign rdy  = mm_q.rdy;
endmodule

// File: rtl/ppt_divider.sv
// Restoring division of the all-ones value 2^deg-1 by dv, one quotient bit per cycle.
module ppt_divider #(
    parameter int W     = 16,
    parameter int DEG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [W-1:0]     dv,
    input  logic [DEG_W-1:0] deg,
    output logic [W-1:0]     quo,
    output logic             rdy
);
    typedef struct packed {
        logic             busy;
        logic             rdy;
        logic [W-1:0]     dv;
        logic [W-1:0]     rem;
        logic [W-1:0]     quo;
        logic [DEG_W-1:0] idx;
    } dv_t;

    dv_t          dv_q, dv_d;
    logic [W:0]   trial;
    logic         ge;
    logic [W-1:0] diff;

    always_comb begin
        trial = {dv_q.rem, 1'b1};
        ge    = (trial >= {1'b0, dv_q.dv});
        diff  = trial[W-1:0] - dv_q.dv;

        dv_d     = dv_q;
        dv_d.rdy = 1'b0;
        if (go) begin
            dv_d.dv   = dv;
            dv_d.rem  = '0;
            dv_d.quo  = '0;
            dv_d.idx  = deg - DEG_W'(1);
            dv_d.busy = 1'b1;
        end else if (dv_q.busy) begin
            dv_d.rem = ge ? diff : trial[W-1:0];
            dv_d.quo = {dv_q.quo[W-2:0], ge};
            if (dv_q.idx == '0) begin
                dv_d.busy = 1'b0;
                dv_d.rdy  = 1'b1;
            end else begin
                dv_d.idx = dv_q.idx - DEG_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign quo = dv_q.quo;
    assign rdy = dv_q.rdy;
endmodule

// File: rtl/ppt_tester.sv
module ppt_tester #(
    parameter int MAX_DEG  = 16,
    parameter int MAX_FACT = 4,
    parameter int DEG_W    = $clog2(MAX_DEG + 1),
    parameter int CNT_W    = $clog2(MAX_FACT + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [DEG_W-1:0]            poly_deg,
    input  logic [MAX_DEG-1:0]          poly_low,
    input  logic [CNT_W-1:0]            fac_cnt,
    input  logic [MAX_FACT*MAX_DEG-1:0] factors,
    output logic                        busy,
    output logic                        done,
    output logic                        is_primitive
);
    import ppt_pkg::*;

    localparam int W = MAX_DEG;

    typedef struct packed {
        ppt_state_e              st;
        logic                    busy;
        logic                    done;
        logic                    prim;
        logic [DEG_W-1:0]        deg;
        logic [W-1:0]            plow;
        logic [CNT_W-1:0]        cnt;
        logic [CNT_W-1:0]        stage;
        logic [MAX_FACT*W-1:0]   fac;
        logic [W-1:0]            expo;
        logic [W-1:0]            res;
        logic [DEG_W-1:0]        bitp;
    } ctl_t;

    ctl_t         ctl_q, ctl_d;
    logic [W-1:0] in_mask, cur_mask, fac_sel;
    logic [W-1:0] mul_prod, prod_x, div_quo;
    logic         mul_rdy, div_rdy, mul_go, div_go;
    logic         expo_bit, bad_in, is_one, stage_fail;

    assign mul_go = (ctl_q.st == ST_SQGO);
    assign div_go = (ctl_q.st == ST_PREP) && (ctl_q.stage != '0);

    ppt_mulmod #(.W(W), .DEG_W(DEG_W)) u_mul (
        .clk(clk), .rst_n(rst_n), .go(mul_go),
        .a(ctl_q.res), .b(ctl_q.res),
        .plow(ctl_q.plow), .deg(ctl_q.deg),
        .prod(mul_prod), .rdy(mul_rdy)
    );

    ppt_divider #(.W(W), .DEG_W(DEG_W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go),
        .dv(fac_sel), .deg(ctl_q.deg),
        .quo(div_quo), .rdy(div_rdy)
    );

    ppt_xstep #(.W(W), .DEG_W(DEG_W)) u_xmul (
        .v(mul_prod), .plow(ctl_q.plow), .deg(ctl_q.deg), .vx(prod_x)
    );

    always_comb begin
        in_mask  = '0;
        cur_mask = '0;
        expo_bit = 1'b0;
        for (int i = 0; i < W; i++) begin
            in_mask[i]  = (i < int'(poly_deg));
            cur_mask[i] = (i < int'(ctl_q.deg));
            if (i == int'(ctl_q.bitp)) expo_bit = ctl_q.expo[i];
        end
        fac_sel = '0;
        for (int k = 0; k < MAX_FACT; k++) begin
            if (int'(ctl_q.stage) == k + 1) fac_sel = ctl_q.fac[k*W +: W];
        end
        bad_in     = (poly_deg == '0) || (int'(poly_deg) > MAX_DEG) || !poly_low[0];
        is_one     = (ctl_q.res == W'(1));
        stage_fail = (ctl_q.stage == '0) ? !is_one : is_one;

        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.prim = 1'b0;
                    if (bad_in) begin
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.deg   = poly_deg;
                        ctl_d.plow  = poly_low & in_mask;
                        ctl_d.cnt   = (fac_cnt > CNT_W'(MAX_FACT)) ? CNT_W'(MAX_FACT) : fac_cnt;
                        ctl_d.fac   = factors;
                        ctl_d.stage = '0;
                        ctl_d.busy  = 1'b1;
                        ctl_d.st    = ST_PREP;
                    end
                end
            end
            ST_PREP: begin
                if (ctl_q.stage == '0) begin
                    ctl_d.expo = cur_mask;
                    ctl_d.st   = ST_EINIT;
                end else begin
                    ctl_d.st = ST_DIVW;
                end
            end
            ST_DIVW: begin
                if (div_rdy) begin
                    ctl_d.expo = div_quo;
                    ctl_d.st   = ST_EINIT;
                end
            end
            ST_EINIT: begin
                ctl_d.res  = W'(1);
                ctl_d.bitp = ctl_q.deg - DEG_W'(1);
                ctl_d.st   = ST_SQGO;
            end
            ST_SQGO: begin
                ctl_d.st = ST_SQW;
            end
            ST_SQW: begin
                if (mul_rdy) begin
                    ctl_d.res = expo_bit ? prod_x : mul_prod;
                    if (ctl_q.bitp == '0) begin
                        ctl_d.st = ST_EVAL;
                    end else begin
                        ctl_d.bitp = ctl_q.bitp - DEG_W'(1);
                        ctl_d.st   = ST_SQGO;
                    end
                end
            end
            ST_EVAL: begin
                if (stage_fail || ctl_q.stage == ctl_q.cnt) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.busy = 1'b0;
                    ctl_d.done = 1'b1;
                    ctl_d.prim = !stage_fail;
                end else begin
                    ctl_d.stage = ctl_q.stage + CNT_W'(1);
                    ctl_d.st    = ST_PREP;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy         = ctl_q.busy;
    assign done         = ctl_q.done;
    assign is_primitive = ctl_q.prim;
endmodule

// File: rtl/ppt_tester_chk.sv
module ppt_tester_chk #(
    parameter int MAX_DEG = 16,
    parameter int DEG_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [DEG_W-1:0]   poly_deg,
    input logic               poly_c0,
    input logic               busy,
    input logic               done,
    input logic               is_primitive
);
    // R5: rejected inputs finish in one cycle without the engine
    p_fast_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (!poly_c0 || poly_deg == '0 || int'(poly_deg) > MAX_DEG))
        |=> (done && !busy && !is_primitive));

    // R7: done is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: busy is low whenever done is reported
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: busy only ends through done
    p_busy_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R9: busy only rises after a start
    p_busy_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R8: verdict held while idle and no start arrives
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(is_primitive));
endmodule

bind ppt_tester ppt_tester_chk #(.MAX_DEG(MAX_DEG), .DEG_W(DEG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .poly_deg(poly_deg),
    .poly_c0(poly_low[0]), .busy(busy), .done(done), .is_primitive(is_primitive)
);

// File: tb/ppt_tester_bench.sv
module ppt_tester_bench;
    localparam int MD = 16;
    localparam int MF = 4;
    localparam int DW = 5;
    localparam int CW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [DW-1:0]   poly_deg = '0;
    logic [MD-1:0]   poly_low = '0;
    logic [CW-1:0]   fac_cnt = '0;
    logic [MF*MD-1:0] factors = '0;
    logic            busy, done, is_primitive;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  reported = 1'b0;

    always #5 clk = ~clk;

    ppt_tester u_ppt_tester (
        .clk(clk), .rst_n(rst_n), .start(start), .poly_deg(poly_deg),
        .poly_low(poly_low), .fac_cnt(fac_cnt), .factors(factors),
        .busy(busy), .done(done), .is_primitive(is_primitive)
    );

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int order_of(int n, int pl);
        int e = (1 << n) - 1;
        int s = 1;
        for (int k = 1; k <= e; k++) begin
            int top = (s >> (n - 1)) & 1;
            s = ((s << 1) & e) ^ (top != 0 ? (pl & e) : 0);
            if (s == 1) return k;
        end
        return 0;
    endfunction

    function automatic bit model(int n, int pl, int cnt, logic [MF*MD-1:0] f);
        int e, o, c;
        if (n < 1 || n > MD || (pl & 1) == 0) return 1'b0;
        e = (1 << n) - 1;
        o = order_of(n, pl & e);
        if (o == 0 || e % o != 0) return 1'b0;
        c = (cnt > MF) ? MF : cnt;
        for (int i = 0; i < c; i++) begin
            int p = int'(f[i*MD +: MD]);
            int q = (p == 0) ? e : e / p;
            if (q % o == 0) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic int prime_list(int n, output logic [MF*MD-1:0] f);
        int x = (1 << n) - 1;
        int c = 0;
        f = '0;
        for (int d = 3; d * d <= x; d += 2) begin
            if (x % d == 0) begin
                if (c < MF) f[c*MD +: MD] = MD'(d);
                c++;
                while (x % d == 0) x = x / d;
            end
        end
        if (x > 1) begin
            if (c < MF) f[c*MD +: MD] = MD'(x);
            c++;
        end
        return c;
    endfunction

    // Runs one test; mid_change perturbs inputs while busy (R9).
    task automatic run_case(input int n, input int pl, input int cnt,
                            input logic [MF*MD-1:0] f, input string req,
                            input bit mid_change);
        bit exp_v = model(n, pl, cnt, f);
        bit rej   = (n < 1 || n > MD || (pl & 1) == 0);
        int waitc = 0;
        @(negedge clk);
        poly_deg = DW'(n);
        poly_low = MD'(pl);
        fac_cnt  = CW'(cnt);
        factors  = f;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (rej) begin
            chk(done && !busy && !is_primitive, {req, " R5 reject"}, int'({done, busy, is_primitive}), 4);
        end else begin
            chk(busy && !done, {req, " R7 busy"}, int'(busy), 1);
            if (mid_change) begin
                factors  = {MF{MD'(3)}};
                fac_cnt  = CW'(MF);
                poly_low = 16'h0000;
                start    = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            while (!done && waitc < 20000) begin
                @(negedge clk);
                waitc++;
            end
            chk(!busy, {req, " R7 idle at done"}, int'(busy), 0);
        end
        chk(done, {req, " done seen"}, int'(done), 1);
        chk(is_primitive == exp_v, req, int'(is_primitive), int'(exp_v));
        @(negedge clk);
        chk(!done && !busy, {req, " R7 pulse"}, int'(done), 0);
        chk(is_primitive == exp_v, {req, " R8 hold"}, int'(is_primitive), int'(exp_v));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [MF*MD-1:0] f;
        int c;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !is_primitive, "R10 reset", int'({busy, done, is_primitive}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !is_primitive, "R10 after release", int'({busy, done, is_primitive}), 0);

        // R4: degree 7, period 127 is prime, no factor stage
        run_case(7, 'h03, 0, '0, "R4 deg7 Mersenne", 1'b0);
        // R1: x^4+x+1 with primes 3,5
        c = prime_list(4, f);
        run_case(4, 'h3, c, f, "R1 x4+x+1", 1'b0);
        // R3: x^4+x^3+x^2+x+1 has order 5
        run_case(4, 'hF, c, f, "R3 order5 quartic", 1'b0);
        // R4: same with no factors passes the full check
        run_case(4, 'hF, 0, '0, "R4 order5 fullonly", 1'b0);
        // R3: count 1 with entry 5 only; entry 3 beyond count ignored
        run_case(4, 'hF, 1, {32'd0, 16'd3, 16'd5}, "R3 beyond count", 1'b0);
        // R3: count above MAX_FACT clamps
        run_case(4, 'h3, 7, {16'd5, 16'd3, 16'd5, 16'd3}, "R3 clamp", 1'b0);
        // R5: zero constant, degree 0, degree too large
        run_case(5, 'h4, 0, '0, "R5 zero const", 1'b0);
        run_case(0, 'h1, 0, '0, "R5 deg0", 1'b0);
        run_case(17, 'h3, 0, '0, "R5 deg17", 1'b0);
        // R11: x+1
        run_case(1, 'h1, 0, '0, "R11 deg1", 1'b0);
        // R2: degree 16, four terms, divisible by x+1
        c = prime_list(16, f);
        run_case(16, 'h1021, c, f, "R2 reducible16", 1'b0);
        // R1: degree 16 primitive x^16+x^14+x^13+x^11+1
        run_case(16, 'h6801, c, f, "R1 prim16", 1'b0);
        // R6: garbage above degree 4
        c = prime_list(4, f);
        run_case(4, 'hFFF3, c, f, "R6 high bits", 1'b0);
        // R9: inputs changed and start pulsed during run
        run_case(4, 'hF, 1, {48'd0, 16'd5}, "R9 midrun change", 1'b1);

        for (int t = 0; t < 40; t++) begin
            int n  = 2 + int'($urandom % 15);
            int pl = int'($urandom & 32'hFFFF);
            if ($urandom % 8 != 0) pl = pl | 1;
            c = prime_list(n, f);
            if (t % 5 == 4 && c > 0) c = int'($urandom % c);
            run_case(n, pl, c, f, "R1 R2 R3 random", 1'b0);
        end
        report();
    end
endmodule